// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block is the refresh side of an SDRAM controller. An interval timer counts down a fixed number of clock cycles. Each time it expires, the block owes the memory one auto-refresh. While anything is owed it raises a request to the main access arbiter. Once the arbiter grants, the block drives the command pins itself. If any bank is still open, it first issues a precharge-all and then waits the row-precharge time. It then issues as many refreshes as are owed, spaced by the row-cycle time.

The block watches the arbiter's own activate, single-bank precharge and precharge-all events so that it knows whether any bank is open. Refreshes that cannot be served at once pile up to a small ceiling. After the last refresh the request stays high for a full row-cycle time, so the arbiter cannot place its next access too early. Clock enable is held high at all times. All timing parameters are counts of clock cycles.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted and just after release, the command pins show deselect (cs_n, ras_n, cas_n, we_n all 1, a10 0), ref_req is 0 and cke is 1. cke stays 1 in every cycle.
- R2: After reset release, ref_req rises after exactly REFI_CYC rising clock edges. From then on, one further refresh is owed every REFI_CYC cycles.
- R3: While ref_gnt is low and no sequence is in progress, no command is driven (cs_n stays 1). A command is driven only while ref_req is high.
- R4: If any bank is open in the cycle the grant is seen, the first command is precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1. It appears in the cycle after the grant is first sampled.
- R5: An auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, a10=0) follows a precharge-all exactly TRP_CYC cycles later.
- R6: If no bank is open when the grant is seen, an auto-refresh is issued in the cycle after the grant is first sampled, with no precharge-all.
- R7: When several refreshes are owed and the grant stays high, consecutive refreshes are exactly TRC_CYC cycles apart.
- R8: ref_req stays high until exactly TRC_CYC cycles after the last refresh of a sequence, and then falls.
- R9: The number of owed refreshes saturates at OWED_MAX. Expiries beyond it are discarded, so a burst after a long wait carries exactly OWED_MAX refreshes.
- R10: A bank becomes open on act_v for bank_sel. It closes on pre_v for the same bank, or for all banks on pre_all_v or on the block's own precharge-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Arbiter hands the command bus to this block |
| act_v | input | 1 | Arbiter issued an activate to bank_sel |
| pre_v | input | 1 | Arbiter issued a single-bank precharge to bank_sel |
| pre_all_v | input | 1 | Arbiter issued a precharge-all |
| bank_sel | input | BA_W | Bank index for act_v / pre_v |
| ref_req | output | 1 | Refresh owed or sequence in progress |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, high for precharge-all |

## Verification
The hardest state to reach is a saturated backlog. The timer must expire more times than the ceiling allows while the grant is withheld, and the burst that follows must not overlap a later expiry. The stimulus first waits for ref_req to rise, which pins the timer phase. It then holds the grant low for three more intervals plus a margin, and grants well before the next expiry. The bench can then count exactly OWED_MAX refreshes and measure their spacing. Bank-open tracking is driven through sequences of activate, single-bank precharge and precharge-all pulses, each followed by a grant to see whether a precharge-all appears.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PALL,
    ST_TRP,
    ST_AREF,
    ST_TRC
  } seq_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } sdr_cmd_t;

  function automatic sdr_cmd_t cmd_desel();
    return '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  endfunction

  function automatic sdr_cmd_t cmd_pall();
    return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
  endfunction

  function automatic sdr_cmd_t cmd_aref();
    return '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
  endfunction

  // next backlog value: add an expiry, remove a served refresh, clip at cap
  function automatic int owed_step(int cur, bit tick, bit served, int cap);
    int nxt;
    nxt = cur + (tick ? 1 : 0) - (served ? 1 : 0);
    if (nxt > cap) nxt = cap;
    if (nxt < 0) nxt = 0;
    return nxt;
  endfunction

endpackage

// File: rtl/refr_interval_timer.sv
module refr_interval_timer #(
  parameter int REFI_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic expire
);
  localparam int TMR_W = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(REFI_CYC - 1);

  logic [TMR_W-1:0] cnt_q;

  assign expire = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RELOAD;
    else if (expire) cnt_q <= RELOAD;
    else             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/refr_owed_ctr.sv
module refr_owed_ctr import sdram_ref_pkg::*; #(
  parameter int OWED_MAX = 4,
  localparam int OWED_W = $clog2(OWED_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              served,
  output logic [OWED_W-1:0] owed,
  output logic              pending
);
  logic [OWED_W-1:0] owed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= OWED_W'(owed_step(int'(owed_q), expire, served, OWED_MAX));
  end

  assign owed    = owed_q;
  assign pending = (owed_q != '0);
endmodule

// File: rtl/bank_open_tracker.sv
module bank_open_tracker #(
  parameter int NBANK = 4,
  localparam int BA_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_v,
  input  logic            pre_v,
  input  logic            pre_all_v,
  input  logic [BA_W-1:0] bank_sel,
  input  logic            own_pall,
  output logic            any_open
);
  logic [NBANK-1:0] open_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (bank_sel == BA_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    open_q[b] <= 1'b0;
      else if (own_pall || pre_all_v) open_q[b] <= 1'b0;
      else if (pre_v && hit)         open_q[b] <= 1'b0;
      else if (act_v && hit)         open_q[b] <= 1'b1;
    end
  end

  assign any_open = |open_q;
endmodule

// File: rtl/refr_seq_fsm.sv
module refr_seq_fsm import sdram_ref_pkg::*; #(
  parameter int TRP_CYC = 3,
  parameter int TRC_CYC = 7
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pending,
  input  logic     gnt,
  input  logic     any_open,
  output logic     issue_pall,
  output logic     issue_aref,
  output logic     seq_active,
  output sdr_cmd_t cmd
);
  localparam int WMAX   = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC;
  localparam int WAIT_W = $clog2(WMAX + 1);

  seq_st_e           st_q, st_d;
  logic [WAIT_W-1:0] wt_q, wt_d;

  always_comb begin
    st_d = st_q;
    wt_d = wt_q;
    case (st_q)
      ST_IDLE: if (pending && gnt) st_d = any_open ? ST_PALL : ST_AREF;
      ST_PALL: begin
        st_d = ST_TRP;
        wt_d = WAIT_W'(TRP_CYC - 2);
      end
      ST_TRP: begin
        if (wt_q == '0) st_d = ST_AREF;
        else            wt_d = wt_q - 1'b1;
      end
      ST_AREF: begin
        st_d = ST_TRC;
        wt_d = WAIT_W'(TRC_CYC - 2);
      end
      ST_TRC: begin
        if (wt_q == '0) st_d = (pending && gnt) ? ST_AREF : ST_IDLE;
        else            wt_d = wt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      wt_q <= '0;
    end else begin
      st_q <= st_d;
      wt_q <= wt_d;
    end
  end

  assign issue_pall = (st_q == ST_PALL);
  assign issue_aref = (st_q == ST_AREF);
  assign seq_active = (st_q != ST_IDLE);
  assign cmd = issue_pall ? cmd_pall() : (issue_aref ? cmd_aref() : cmd_desel());
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched import sdram_ref_pkg::*; #(
  parameter int REFI_CYC = 1560,
  parameter int TRP_CYC  = 3,
  parameter int TRC_CYC  = 7,
  parameter int OWED_MAX = 4,
  parameter int NBANK    = 4,
  localparam int BA_W    = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int OWED_W  = $clog2(OWED_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_gnt,
  input  logic            act_v,
  input  logic            pre_v,
  input  logic            pre_all_v,
  input  logic [BA_W-1:0] bank_sel,
  output logic            ref_req,
  output logic            cke,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            a10
);
  logic              expire;
  logic              pending;
  logic [OWED_W-1:0] owed_q;
  logic              any_open;
  logic              issue_pall;
  logic              issue_aref;
  logic              seq_active;
  sdr_cmd_t          cmd;

  refr_interval_timer #(.REFI_CYC(REFI_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .expire(expire)
  );

  refr_owed_ctr #(.OWED_MAX(OWED_MAX)) u_owed (
    .clk(clk), .rst_n(rst_n), .expire(expire), .served(issue_aref),
    .owed(owed_q), .pending(pending)
  );

  bank_open_tracker #(.NBANK(NBANK)) u_banks (
    .clk(clk), .rst_n(rst_n), .act_v(act_v), .pre_v(pre_v),
    .pre_all_v(pre_all_v), .bank_sel(bank_sel), .own_pall(issue_pall),
    .any_open(any_open)
  );

  refr_seq_fsm #(.TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pending(pending), .gnt(ref_gnt),
    .any_open(any_open), .issue_pall(issue_pall), .issue_aref(issue_aref),
    .seq_active(seq_active), .cmd(cmd)
  );

  assign ref_req = pending | seq_active;
  assign cke     = 1'b1;
  assign cs_n    = cmd.cs_n;
  assign ras_n   = cmd.ras_n;
  assign cas_n   = cmd.cas_n;
  assign we_n    = cmd.we_n;
  assign a10     = cmd.a10;
endmodule

// File: rtl/refr_sched_chk.sv
module refr_sched_chk #(
  parameter int TRP_CYC  = 3,
  parameter int TRC_CYC  = 7,
  parameter int OWED_MAX = 4,
  parameter int OWED_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              a10,
  input logic              ref_req,
  input logic              any_open,
  input logic [OWED_W-1:0] owed
);
  logic is_ref, is_pall;
  int   since_ref, since_pall;

  assign is_ref  = !cs_n && !ras_n && !cas_n && we_n && !a10;
  assign is_pall = !cs_n && !ras_n && cas_n && !we_n && a10;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ref  <= TRC_CYC;
      since_pall <= TRP_CYC;
    end else begin
      if (is_ref) since_ref <= 1;
      else if (since_ref < TRC_CYC) since_ref <= since_ref + 1;
      if (is_pall) since_pall <= 1;
      else if (since_pall < TRP_CYC) since_pall <= since_pall + 1;
    end
  end

  // R3
  cmd_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> ref_req);

  // R4
  ref_banks_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> !any_open);

  // R5
  pall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> since_pall >= TRP_CYC);

  // R7
  ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> since_ref >= TRC_CYC);

  // R8
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_req) |-> since_ref >= TRC_CYC);

  // R9
  owed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owed) <= OWED_MAX);
endmodule

bind sdram_refresh_sched refr_sched_chk #(
  .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC), .OWED_MAX(OWED_MAX), .OWED_W(OWED_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .a10(a10), .ref_req(ref_req), .any_open(any_open), .owed(owed_q)
);

// File: tb/sim_sdram_refresh_sched.sv
`timescale 1ns/1ps
module sim_sdram_refresh_sched;
  localparam int INTV = 50;
  localparam int TRP  = 3;
  localparam int TRC  = 6;
  localparam int OMAX = 3;
  localparam int NB   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0, act_v = 1'b0, pre_v = 1'b0, pre_all_v = 1'b0;
  logic [1:0] bank_sel = '0;
  logic ref_req, cke, cs_n, ras_n, cas_n, we_n, a10;

  always #4 clk = ~clk;

  sdram_refresh_sched #(.REFI_CYC(INTV), .TRP_CYC(TRP), .TRC_CYC(TRC),
                        .OWED_MAX(OMAX), .NBANK(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .act_v(act_v), .pre_v(pre_v),
    .pre_all_v(pre_all_v), .bank_sel(bank_sel), .ref_req(ref_req), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int ref_q[$];
  int pall_q[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: times of scheduled events rather than states
  int m_tmr, m_owed, m_cmd, m_due, m_rcend, m_n;
  bit [NB-1:0] m_open;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tmr = INTV - 1; m_owed = 0; m_cmd = 0; m_due = -1; m_rcend = -1;
      m_n = 0; m_open = '0; cyc = 0;
    end else begin
      bit tick, served, anyo, gset;
      int old_owed, nc;
      cyc++;
      m_n++;
      tick = (m_tmr == 0);
      m_tmr = tick ? INTV - 1 : m_tmr - 1;
      served = (m_cmd == 2);
      anyo = |m_open;
      old_owed = m_owed;
      gset = (old_owed > 0) && ref_gnt;
      nc = 0;
      if (m_due == m_n) begin
        nc = 2; m_due = -1; m_rcend = m_n + TRC;
      end else if (m_rcend == m_n) begin
        m_rcend = -1;
        if (gset) begin nc = 2; m_rcend = m_n + TRC; end
      end else if (m_due == -1 && m_rcend == -1 && gset) begin
        if (anyo) begin nc = 1; m_due = m_n + TRP; end
        else      begin nc = 2; m_rcend = m_n + TRC; end
      end
      m_owed = old_owed + (tick ? 1 : 0) - (served ? 1 : 0);
      if (m_owed > OMAX) m_owed = OMAX;
      if (m_cmd == 1 || pre_all_v) m_open = '0;
      else begin
        if (act_v) m_open[bank_sel] = 1'b1;
        if (pre_v) m_open[bank_sel] = 1'b0;
      end
      m_cmd = nc;
    end
  end

  // every-cycle comparison plus pin-level event log
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [4:0] exp_pins, got_pins;
      bit exp_req;
      exp_pins = (m_cmd == 1) ? 5'b00101 : (m_cmd == 2) ? 5'b00010 : 5'b11110;
      got_pins = {cs_n, ras_n, cas_n, we_n, a10};
      exp_req = (m_owed > 0) || (m_cmd != 0) || (m_due != -1) || (m_rcend != -1);
      chk(got_pins == exp_pins,
          (m_cmd == 1) ? "R4 pins" : (m_cmd == 2) ? "R5 pins" : "R3 pins",
          got_pins, exp_pins);
      chk(ref_req == exp_req, "R8 ref_req", ref_req, exp_req);
      chk(cke == 1'b1, "R1 cke", cke, 1);
      if (got_pins == 5'b00101) pall_q.push_back(cyc);
      if (got_pins == 5'b00010) ref_q.push_back(cyc);
    end
  end

  task automatic wait_req_rise(output int at);
    at = -1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (ref_req) begin at = cyc; break; end
    end
  endtask

  task automatic wait_req_fall(output int at);
    at = -1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!ref_req) begin at = cyc; break; end
    end
    ref_gnt = 1'b0;
  endtask

  task automatic pulse(input bit a, input bit p, input bit pa, input int b);
    @(negedge clk);
    act_v = a; pre_v = p; pre_all_v = pa; bank_sel = 2'(b);
    @(negedge clk);
    act_v = 0; pre_v = 0; pre_all_v = 0;
  endtask

  task automatic grant_and_finish(output int g, output int fall);
    ref_q.delete(); pall_q.delete();
    ref_gnt = 1'b1; g = cyc;
    wait_req_fall(fall);
  endtask

  initial begin
    int n, at, g, fall;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: deselect, no request, cke high during reset
    chk({cs_n, ras_n, cas_n, we_n, a10, ref_req, cke} == 7'b1111001, "R1 reset",
        {cs_n, ras_n, cas_n, we_n, a10, ref_req, cke}, 7'b1111001);
    rst_n = 1'b1;

    // R2: first request after exactly INTV edges
    n = 0;
    for (int i = 0; i < 500; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (ref_req) break;
    end
    chk(n == INTV, "R2 first request", n, INTV);

    // R3: no command while grant withheld
    repeat (20) @(negedge clk);
    chk(ref_q.size() + pall_q.size() == 0, "R3 no cmd w/o grant",
        ref_q.size() + pall_q.size(), 0);

    // R6: banks closed, refresh immediately after grant
    grant_and_finish(g, fall);
    chk(ref_q.size() == 1 && ref_q[0] == g + 1, "R6 direct refresh",
        ref_q.size() ? ref_q[0] : -1, g + 1);
    chk(pall_q.size() == 0, "R6 no precharge-all", pall_q.size(), 0);
    chk(fall == g + 1 + TRC, "R8 release after tRC", fall, g + 1 + TRC);

    // R4/R5: open bank forces precharge-all, refresh tRP later
    pulse(1, 0, 0, 2);
    wait_req_rise(at);
    grant_and_finish(g, fall);
    chk(pall_q.size() == 1 && pall_q[0] == g + 1, "R4 precharge-all first",
        pall_q.size() ? pall_q[0] : -1, g + 1);
    chk(ref_q.size() == 1 && ref_q[0] == g + 1 + TRP, "R5 refresh after tRP",
        ref_q.size() ? ref_q[0] : -1, g + 1 + TRP);

    // R9/R7: saturated backlog served back to back
    wait_req_rise(at);
    repeat (3 * INTV + 10) @(negedge clk);
    grant_and_finish(g, fall);
    chk(ref_q.size() == OMAX, "R9 burst size at cap", ref_q.size(), OMAX);
    if (ref_q.size() >= 3) begin
      chk(ref_q[1] - ref_q[0] == TRC, "R7 spacing 1", ref_q[1] - ref_q[0], TRC);
      chk(ref_q[2] - ref_q[1] == TRC, "R7 spacing 2", ref_q[2] - ref_q[1], TRC);
      chk(fall == ref_q[2] + TRC, "R8 release after burst", fall, ref_q[2] + TRC);
    end

    // R10: activate then precharge same bank -> closed
    pulse(1, 0, 0, 1);
    pulse(0, 1, 0, 1);
    wait_req_rise(at);
    grant_and_finish(g, fall);
    chk(pall_q.size() == 0, "R10 single precharge closes", pall_q.size(), 0);

    // R10: two opened, one closed -> still open
    pulse(1, 0, 0, 0);
    pulse(1, 0, 0, 3);
    pulse(0, 1, 0, 0);
    wait_req_rise(at);
    grant_and_finish(g, fall);
    chk(pall_q.size() == 1, "R10 other bank stays open", pall_q.size(), 1);

    // R10: arbiter precharge-all closes everything
    pulse(1, 0, 0, 2);
    pulse(0, 0, 1, 0);
    wait_req_rise(at);
    grant_and_finish(g, fall);
    chk(pall_q.size() == 0, "R10 external precharge-all", pall_q.size(), 0);

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule